// File: doc/BRIEF.md
# Paged Host Control Register File

This block is the host side of a byte-wide network controller. A host reaches it through a 4-bit offset together with read and write enables. The offset is decoded against a two-bit page number that is kept inside the command register. The command register, which also chooses the page, can be reached at offset 0 whatever page is selected.

The block holds three things. The command register turns host writes into single-cycle strobes for the engines: start, stop, transmit, and remote-DMA command. The interrupt status register gathers single-cycle event pulses from the transmit, receive, DMA and counter logic. The interrupt mask register sets which of those status bits drive the level interrupt line.

A bank of six station-address bytes and a current-receive-page byte is kept on page 1. Both are plain storage, and their contents are also driven out to the receive logic. When a stop has been commanded and the engines report that they are idle, the block raises a dedicated reset-status flag.

Top module: `netc_host_regs`

## Requirements
- R1: After reset: the command register reads 0x21 (stopped, DMA code 4, page 0), the status register reads 0x80, the mask register reads 0x00, page-1 storage reads 0, `irq` is low, and all strobes are low.
- R2: The command register is at offset 0 on every page. Its bits 7:6 select the page used to decode the other offsets, for both reads and writes: 0 = main, 1 = station, 2 = shadow. On page 3, every offset except 0 reads as 0 and ignores writes. A new page applies from the access after the write that selects it.
- R3: A command write with bit0 = 1 puts the block in the stopped state (bit0 = 1, bit1 = 0) and pulses `stop_go` in the next cycle. A write with bit1 = 1 and bit0 = 0 puts it in the started state (bit0 = 0, bit1 = 1) and pulses `start_go`. A write with neither bit set leaves the run state unchanged.
- R4: Command bit2 (transmit) becomes set, and `tx_go` pulses, only when it is written as 1 and the run state after that write is started. A write while the block remains stopped is ignored. Writing 0 does not clear the bit. It reads back as 1 until a transmit-ok event (bit1) or a transmit-error event (bit3) arrives; a new accepted transmit write in the same cycle keeps it set.
- R5: A command write whose bits 5:3 hold 1 (read), 2 (write), 3 (send) or 4 (abort) stores that code and pulses `dma_go` with the code on `dma_op`. The codes 0, 5, 6 and 7 leave the stored code unchanged and produce no pulse.
- R6: The status register is at page 0, offset 7. Pulse `ev_pulse[i]` sets status bit i in the next cycle. The bit order is: 0 received, 1 transmitted, 2 receive error, 3 transmit error, 4 overwrite warning, 5 counter overflow, 6 remote DMA done.
- R7: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged; 0xFF clears every bit.
- R8: An event that sets a status bit, including bit 7, in the same cycle as a host write that clears that bit wins: the bit stays set.
- R9: The mask register is written at page 0, offset 15, and read at page 2, offset 15. Bit 7 always reads 0. `irq` is the OR of status AND mask over bits 0 to 6, and status bit 7 never raises `irq`.
- R10: After a stop write, status bit 7 is set in the cycle after the first cycle, following that write, in which `eng_idle` is high. A start write before that cancels the pending flag.
- R11: On page 1, offsets 1 to 6 hold station-address bytes 0 to 5, and offset 1 drives `station_addr[7:0]`. Offset 7 holds the current receive page, driven on `cur_page`. All of these read back their stored values.
- R12: `rdata` is registered: it takes the addressed value, as it was before any write in the same cycle, one cycle after `rd_en`, and holds it while `rd_en` is low. Offsets with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| ofs | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| ev_pulse | input | 7 | Single-cycle event pulses, bit i sets status bit i |
| eng_idle | input | 1 | Engines have come to rest |
| start_go | output | 1 | Start strobe |
| stop_go | output | 1 | Stop strobe |
| tx_go | output | 1 | Transmit strobe |
| dma_go | output | 1 | Remote-DMA command strobe |
| dma_op | output | 3 | Remote-DMA code sent with `dma_go` |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| cur_page | output | 8 | Current receive page |
| irq | output | 1 | Level interrupt |

## Verification
An engine event and a host write-one-to-clear of the same status bit can land in the same cycle. So can the engine-idle indication and a host clear of the reset-status bit. The bench drives `ev_pulse`, or raises `eng_idle` while a stop is pending, on the very cycle that it writes ones to the status register. It then reads the register back and expects the event's bit to still be set, while the bits that were only cleared go to 0. A transmit-done event that meets a new accepted transmit write is judged the same way, by reading the command register back.

// File: rtl/netc_regs_pkg.sv
package netc_regs_pkg;

  typedef enum logic [1:0] {
    PG_MAIN    = 2'd0,
    PG_STATION = 2'd1,
    PG_SHADOW  = 2'd2,
    PG_RSVD    = 2'd3
  } page_e;

  typedef struct packed {
    logic [1:0] page;
    logic [2:0] dma;
    logic       tx;
    logic       start;
    logic       stop;
  } cmd_t;

  localparam logic [2:0] DMA_RD    = 3'd1;
  localparam logic [2:0] DMA_ABORT = 3'd4;

  localparam int TX_OK_BIT  = 1;
  localparam int TX_ERR_BIT = 3;

  function automatic logic dma_code_ok(input logic [2:0] code);
    return (code >= DMA_RD) && (code <= DMA_ABORT);
  endfunction

endpackage

// File: rtl/netc_cmd_unit.sv
module netc_cmd_unit
  import netc_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  input  logic       tx_end,
  input  logic       eng_idle,
  output cmd_t       cmd_q,
  output logic       rst_evt,
  output logic       start_go,
  output logic       stop_go,
  output logic       tx_go,
  output logic       dma_go,
  output logic [2:0] dma_op
);

  cmd_t wr_c;
  logic pend_q;
  logic stop_wr, start_wr, nxt_start, tx_accept, dma_accept;

  assign wr_c       = cmd_t'(wdata);
  assign stop_wr    = cmd_wr && wr_c.stop;
  assign start_wr   = cmd_wr && !wr_c.stop && wr_c.start;
  assign nxt_start  = stop_wr ? 1'b0 : (start_wr ? 1'b1 : cmd_q.start);
  assign tx_accept  = cmd_wr && wr_c.tx && nxt_start;
  assign dma_accept = cmd_wr && dma_code_ok(wr_c.dma);
  assign rst_evt    = pend_q && eng_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '{page: 2'd0, dma: DMA_ABORT, tx: 1'b0, start: 1'b0, stop: 1'b1};
      pend_q   <= 1'b0;
      start_go <= 1'b0;
      stop_go  <= 1'b0;
      tx_go    <= 1'b0;
      dma_go   <= 1'b0;
      dma_op   <= '0;
    end else begin
      if (stop_wr) begin
        cmd_q.stop  <= 1'b1;
        cmd_q.start <= 1'b0;
      end else if (start_wr) begin
        cmd_q.stop  <= 1'b0;
        cmd_q.start <= 1'b1;
      end
      if (cmd_wr)     cmd_q.page <= wr_c.page;
      if (dma_accept) cmd_q.dma  <= wr_c.dma;
      if (tx_accept)   cmd_q.tx <= 1'b1;
      else if (tx_end) cmd_q.tx <= 1'b0;

      if (stop_wr)                   pend_q <= 1'b1;
      else if (start_wr || rst_evt)  pend_q <= 1'b0;

      start_go <= start_wr;
      stop_go  <= stop_wr;
      tx_go    <= tx_accept;
      dma_go   <= dma_accept;
      dma_op   <= dma_accept ? wr_c.dma : 3'd0;
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_go, stop_go}));

  // R4
  tx_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_q.tx) |-> cmd_q.start);

  // R5
  dma_code_chk: assert property (@(posedge clk) disable iff (rst)
    dma_go |-> (dma_op != 3'd0 && dma_op <= DMA_ABORT));

  // R10
  pend_stop_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> cmd_q.stop);

endmodule

// File: rtl/netc_irq_unit.sv
module netc_irq_unit #(
  parameter int NUM_EV = 7,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              rst_evt,
  input  logic              isr_wr,
  input  logic              imr_wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     isr_q,
  output logic [DW-1:0]     imr_q,
  output logic              irq
);

  localparam int NST = NUM_EV + 1;

  logic [NST-1:0] set_vec;
  logic [NST-1:0] clr;
  logic [NST-1:0] stat_q;
  logic [NUM_EV-1:0] mask_q;

  assign set_vec = {rst_evt, ev};
  assign clr     = isr_wr ? wdata[NST-1:0] : '0;

  for (genvar b = 0; b < NST; b++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst)             stat_q[b] <= (b == NUM_EV);
      else if (set_vec[b]) stat_q[b] <= 1'b1;
      else if (clr[b])     stat_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (imr_wr) mask_q <= wdata[NUM_EV-1:0];
  end

  assign isr_q = DW'(stat_q);
  assign imr_q = DW'(mask_q);
  assign irq   = |(stat_q[NUM_EV-1:0] & mask_q);

  // R7
  isr_w1c_only_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(stat_q) & ~stat_q & ~$past(clr)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|stat_q[NUM_EV-1:0]));

endmodule

// File: rtl/netc_station_bank.sv
module netc_station_bank #(
  parameter int NBYTES = 6,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stn_wr,
  input  logic [IDX_W-1:0]     stn_idx,
  input  logic                 cur_wr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        stn_rd,
  output logic [NBYTES*DW-1:0] station_addr,
  output logic [DW-1:0]        cur_page
);

  localparam int IDX_W = $clog2(NBYTES);

  logic [DW-1:0] mem [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                                  mem[i] <= '0;
      else if (stn_wr && stn_idx == IDX_W'(i))  mem[i] <= wdata;
    end
    assign station_addr[i*DW +: DW] = mem[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         cur_page <= '0;
    else if (cur_wr) cur_page <= wdata;
  end

  always_comb begin
    stn_rd = '0;
    for (int i = 0; i < NBYTES; i++)
      if (stn_idx == IDX_W'(i)) stn_rd = mem[i];
  end

  // R11
  stn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stn_wr |=> $stable(station_addr));

  // R11
  cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cur_wr |=> $stable(cur_page));

endmodule

// File: rtl/netc_host_regs.sv
module netc_host_regs
  import netc_regs_pkg::*;
#(
  parameter int OFS_W  = 4,
  parameter int DW     = 8,
  parameter int NUM_EV = 7,
  parameter int NBYTES = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NUM_EV-1:0]    ev_pulse,
  input  logic                 eng_idle,
  output logic                 start_go,
  output logic                 stop_go,
  output logic                 tx_go,
  output logic                 dma_go,
  output logic [2:0]           dma_op,
  output logic [NBYTES*DW-1:0] station_addr,
  output logic [DW-1:0]        cur_page,
  output logic                 irq
);

  localparam logic [OFS_W-1:0] OFS_CMD   = '0;
  localparam logic [OFS_W-1:0] OFS_ISR   = OFS_W'(7);
  localparam logic [OFS_W-1:0] OFS_IMR   = '1;
  localparam logic [OFS_W-1:0] OFS_STN0  = OFS_W'(1);
  localparam logic [OFS_W-1:0] OFS_CURPG = OFS_W'(NBYTES + 1);
  localparam int IDX_W = $clog2(NBYTES);

  cmd_t          cmd_q;
  page_e         pg;
  logic          rst_evt, tx_end;
  logic          cmd_wr, isr_wr, imr_wr, stn_hit, stn_wr, cur_wr;
  logic [IDX_W-1:0] stn_idx;
  logic [DW-1:0] isr_q, imr_q, stn_rd, rd_mux;

  assign pg      = page_e'(cmd_q.page);
  assign tx_end  = ev_pulse[TX_OK_BIT] | ev_pulse[TX_ERR_BIT];
  assign stn_hit = (ofs >= OFS_STN0) && (ofs < OFS_STN0 + OFS_W'(NBYTES));
  assign stn_idx = IDX_W'(ofs - OFS_STN0);
  assign cmd_wr  = wr_en && (ofs == OFS_CMD);
  assign isr_wr  = wr_en && (pg == PG_MAIN)    && (ofs == OFS_ISR);
  assign imr_wr  = wr_en && (pg == PG_MAIN)    && (ofs == OFS_IMR);
  assign stn_wr  = wr_en && (pg == PG_STATION) && stn_hit;
  assign cur_wr  = wr_en && (pg == PG_STATION) && (ofs == OFS_CURPG);

  netc_cmd_unit u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .wdata    (wdata),
    .tx_end   (tx_end),
    .eng_idle (eng_idle),
    .cmd_q    (cmd_q),
    .rst_evt  (rst_evt),
    .start_go (start_go),
    .stop_go  (stop_go),
    .tx_go    (tx_go),
    .dma_go   (dma_go),
    .dma_op   (dma_op)
  );

  netc_irq_unit #(.NUM_EV(NUM_EV), .DW(DW)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev_pulse),
    .rst_evt (rst_evt),
    .isr_wr  (isr_wr),
    .imr_wr  (imr_wr),
    .wdata   (wdata),
    .isr_q   (isr_q),
    .imr_q   (imr_q),
    .irq     (irq)
  );

  netc_station_bank #(.NBYTES(NBYTES), .DW(DW)) u_stn (
    .clk          (clk),
    .rst          (rst),
    .stn_wr       (stn_wr),
    .stn_idx      (stn_idx),
    .cur_wr       (cur_wr),
    .wdata        (wdata),
    .stn_rd       (stn_rd),
    .station_addr (station_addr),
    .cur_page     (cur_page)
  );

  always_comb begin
    rd_mux = '0;
    if (ofs == OFS_CMD) begin
      rd_mux = DW'(cmd_q);
    end else begin
      case (pg)
        PG_MAIN:    if (ofs == OFS_ISR) rd_mux = isr_q;
        PG_STATION: begin
          if (stn_hit)                rd_mux = stn_rd;
          else if (ofs == OFS_CURPG)  rd_mux = cur_page;
        end
        PG_SHADOW:  if (ofs == OFS_IMR) rd_mux = imr_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R2
  rsvd_page_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pg == PG_RSVD && ofs != OFS_CMD) |=> ($stable(imr_q) && $stable(station_addr) && $stable(cur_page)));

endmodule

// File: tb/netc_host_regs_test.sv
module netc_host_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  ofs = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [6:0]  ev_pulse = '0;
  logic        eng_idle = 1'b0;
  logic        start_go, stop_go, tx_go, dma_go, irq;
  logic [2:0]  dma_op;
  logic [47:0] station_addr;
  logic [7:0]  cur_page;

  int total = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  netc_host_regs uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .ofs(ofs),
    .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse), .eng_idle(eng_idle),
    .start_go(start_go), .stop_go(stop_go), .tx_go(tx_go), .dma_go(dma_go),
    .dma_op(dma_op), .station_addr(station_addr), .cur_page(cur_page), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int   m_page, m_dma, m_tx, m_start, m_stop, m_pend;
  logic [7:0] m_isr, m_imr, m_cur, m_rdata, rv, clrv, setv;
  logic [7:0] m_stn [6];
  logic m_sgo, m_pgo, m_tgo, m_dgo;
  int   m_dop, pg, idle_ev;

  function automatic logic [7:0] m_cmd();
    return {m_page[1:0], m_dma[2:0], m_tx[0], m_start[0], m_stop[0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_page = 0; m_dma = 4; m_tx = 0; m_start = 0; m_stop = 1; m_pend = 0;
      m_isr = 8'h80; m_imr = 0; m_cur = 0; m_rdata = 0;
      foreach (m_stn[i]) m_stn[i] = 0;
      m_sgo = 0; m_pgo = 0; m_tgo = 0; m_dgo = 0; m_dop = 0;
    end else begin
      pg = m_page;
      rv = 0;
      if (ofs == 0) rv = m_cmd();
      else if (pg == 0 && ofs == 7) rv = m_isr;
      else if (pg == 1 && ofs >= 1 && ofs <= 6) rv = m_stn[ofs-1];
      else if (pg == 1 && ofs == 7) rv = m_cur;
      else if (pg == 2 && ofs == 15) rv = m_imr;
      if (rd_en) m_rdata = rv;

      idle_ev = (m_pend != 0 && eng_idle) ? 1 : 0;
      setv = {idle_ev[0], ev_pulse};
      clrv = (wr_en && pg == 0 && ofs == 7) ? wdata : 8'h00;
      m_isr = (m_isr & ~clrv) | setv;
      if (wr_en && pg == 0 && ofs == 15) m_imr = wdata & 8'h7F;
      if (wr_en && pg == 1 && ofs >= 1 && ofs <= 6) m_stn[ofs-1] = wdata;
      if (wr_en && pg == 1 && ofs == 7) m_cur = wdata;

      m_sgo = 0; m_pgo = 0; m_tgo = 0; m_dgo = 0; m_dop = 0;
      if (idle_ev != 0) m_pend = 0;
      if (wr_en && ofs == 0) begin
        if (wdata[0]) begin m_stop = 1; m_start = 0; m_pgo = 1; m_pend = 1; end
        else if (wdata[1]) begin m_stop = 0; m_start = 1; m_sgo = 1; m_pend = 0; end
        m_page = wdata[7:6];
        if (wdata[5:3] >= 1 && wdata[5:3] <= 4) begin
          m_dma = wdata[5:3]; m_dgo = 1; m_dop = wdata[5:3];
        end
      end
      if (wr_en && ofs == 0 && wdata[2] && m_start != 0) begin m_tx = 1; m_tgo = 1; end
      else if (ev_pulse[1] || ev_pulse[3]) m_tx = 0;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [47:0] m_flat;
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < 6; i++) m_flat[i*8 +: 8] = m_stn[i];
      chk(cur_req, "rdata", rdata, m_rdata);
      chk(cur_req, "irq", irq, |(m_isr[6:0] & m_imr[6:0]));
      chk(cur_req, "strobes", {start_go, stop_go, tx_go, dma_go, dma_op},
          {m_sgo, m_pgo, m_tgo, m_dgo, m_dop[2:0]});
      chk(cur_req, "station_addr", station_addr, m_flat);
      chk(cur_req, "cur_page", cur_page, m_cur);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] o, input logic [7:0] d, input logic [6:0] ev = '0);
    @(negedge clk); wr_en = 1; ofs = o; wdata = d; ev_pulse = ev;
    @(negedge clk); wr_en = 0; ev_pulse = '0;
  endtask

  task automatic pulse(input logic [6:0] ev);
    @(negedge clk); ev_pulse = ev;
    @(negedge clk); ev_pulse = '0;
  endtask

  task automatic rd_expect(input logic [3:0] o, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1; ofs = o;
    @(negedge clk); rd_en = 0;
    chk(tag, $sformatf("read ofs %0d", o), rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "strobes after reset", {start_go, stop_go, tx_go, dma_go}, 0);
    rd_expect(0, 8'h21, "R1");
    rd_expect(7, 8'h80, "R1");

    cur_req = "R11";
    wr(0, 8'h61);
    for (int i = 1; i <= 6; i++) wr(i[3:0], 8'h10 + i[7:0]);
    wr(7, 8'h4C);
    rd_expect(3, 8'h13, "R11");
    rd_expect(7, 8'h4C, "R11");
    chk("R11", "station_addr", station_addr, 48'h161514131211);
    chk("R11", "cur_page", cur_page, 8'h4C);

    cur_req = "R2";
    rd_expect(0, 8'h61, "R2");
    wr(0, 8'hE1);
    wr(7, 8'h55);
    wr(15, 8'h7F);
    rd_expect(7, 8'h00, "R2");
    wr(0, 8'h61);
    rd_expect(7, 8'h4C, "R2");
    wr(0, 8'hA1);
    rd_expect(15, 8'h00, "R2");
    wr(0, 8'h21);

    cur_req = "R12";
    rd_expect(3, 8'h00, "R12");
    repeat (3) @(negedge clk);
    chk("R12", "rdata held", rdata, 8'h00);

    cur_req = "R7";
    wr(7, 8'hFF);
    rd_expect(7, 8'h00, "R7");

    cur_req = "R6";
    pulse(7'h01); pulse(7'h04); pulse(7'h40);
    rd_expect(7, 8'h45, "R6");
    pulse(7'h3A);
    rd_expect(7, 8'h7F, "R6");

    cur_req = "R7";
    wr(7, 8'h0F);
    rd_expect(7, 8'h70, "R7");

    cur_req = "R9";
    wr(15, 8'hC0);
    @(negedge clk);
    chk("R9", "irq masked in", irq, 1);
    wr(0, 8'hA1);
    rd_expect(15, 8'h40, "R9");
    wr(0, 8'h21);
    wr(7, 8'h40);
    @(negedge clk);
    chk("R9", "irq after clear", irq, 0);
    wr(15, 8'h7F);
    wr(7, 8'hFF);

    cur_req = "R8";
    pulse(7'h03);
    wr(7, 8'h03, 7'h02);
    rd_expect(7, 8'h02, "R8");
    wr(7, 8'hFF);

    cur_req = "R3";
    wr(0, 8'h22);
    rd_expect(0, 8'h22, "R3");
    wr(0, 8'h20);
    rd_expect(0, 8'h22, "R3");
    wr(0, 8'h23);
    rd_expect(0, 8'h21, "R3");

    cur_req = "R4";
    wr(0, 8'h24);
    rd_expect(0, 8'h21, "R4");
    wr(0, 8'h26);
    rd_expect(0, 8'h26, "R4");
    wr(0, 8'h22);
    rd_expect(0, 8'h26, "R4");
    pulse(7'h02);
    rd_expect(0, 8'h22, "R4");
    wr(0, 8'h26);
    pulse(7'h08);
    rd_expect(0, 8'h22, "R4");
    wr(0, 8'h26, 7'h02);
    rd_expect(0, 8'h26, "R4");
    pulse(7'h02);
    wr(7, 8'hFF);

    cur_req = "R5";
    wr(0, 8'h0A);
    rd_expect(0, 8'h0A, "R5");
    wr(0, 8'h2A);
    rd_expect(0, 8'h0A, "R5");
    wr(0, 8'h02);
    rd_expect(0, 8'h0A, "R5");
    wr(0, 8'h1A);
    rd_expect(0, 8'h1A, "R5");

    cur_req = "R10";
    eng_idle = 0;
    wr(0, 8'h21);
    wr(7, 8'hFF);
    repeat (4) @(negedge clk);
    rd_expect(7, 8'h00, "R10");
    eng_idle = 1;
    @(negedge clk); eng_idle = 0;
    rd_expect(7, 8'h80, "R10");
    wr(7, 8'h80);
    wr(0, 8'h22);
    wr(0, 8'h21);
    wr(0, 8'h22);
    eng_idle = 1;
    repeat (3) @(negedge clk);
    eng_idle = 0;
    rd_expect(7, 8'h00, "R10");

    cur_req = "R8";
    wr(0, 8'h21);
    @(negedge clk); wr_en = 1; ofs = 7; wdata = 8'h80; eng_idle = 1;
    @(negedge clk); wr_en = 0; eng_idle = 0;
    rd_expect(7, 8'h80, "R8");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL %s watchdog: actual hung expected finished", cur_req);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule